// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache

This block is a 16-Kbyte data cache between a load/store requester and a line-oriented memory port. Storage is four ways of 128 sets, each set holding one 32-byte line per way together with its tag, a valid bit and a dirty bit. A cached access looks up all four tags at once. A load hit returns one 64-bit doubleword. A store hit merges the enabled bytes into the line in the same cycle and marks the line modified.

On a miss the cache picks a victim. It takes the lowest-numbered invalid way if there is one, and otherwise follows a three-bit tree pseudo-LRU state kept per set. A modified victim is first written out as a whole line. The missing line is then fetched. After the fetch is acknowledged, the held request is looked up again and served as a hit. A request flagged as cache-inhibited skips the arrays completely and goes out as a single-beat transfer.

The requester keeps its request steady until `req_ready` is high. The response follows exactly one cycle after that.

Top module: `dcache_core`

## Requirements
- R1: Address bits [31:12] form the tag, bits [11:5] select one of 128 sets, and bits [4:3] select which of the four doublewords in the 32-byte line is accessed. Doubleword k of a line occupies line bits [64k+63:64k].
- R2: A cached load that hits raises `req_ready` in the cycle it is presented. In the next cycle `rsp_valid` is high and `rsp_rdata` carries the addressed doubleword. No memory transfer takes place.
- R3: A cached store that hits replaces byte i (bits 8i+7:8i) of the addressed doubleword when `req_be[i]` is 1 and keeps the other bytes. The whole read-modify-write completes in one cycle. The line becomes dirty, and the response carries the merged doubleword.
- R4: Each set keeps tree bits {b2,b1,b0}. b0=1 selects ways 2/3 and b0=0 selects ways 0/1. b1 then picks way 1 over way 0, and b2 picks way 3 over way 2. Every hit or fill of way w sets the bits so that they point away from w.
- R5: When a set has an invalid way, the victim is the lowest-numbered invalid way, whatever the tree bits are.
- R6: On a miss whose victim is valid and dirty, a line write (`mem_write`=1, `mem_single`=0) is issued first, to the victim's line-aligned address. A clean or invalid victim produces no write.
- R7: A miss fetches the line with `mem_write`=0 and `mem_single`=0 at the line-aligned address. After `mem_ack` the line is installed clean and valid, and the held request is then served as a hit.
- R8: An inhibited request goes out with `mem_single`=1, the full address, `req_be` and its data on bits [63:0]. The response returns `mem_rdata[63:0]`. No line is allocated, so a later cached access to that line misses.
- R9: Reset invalidates every line and clears every set's tree bits. While reset is active, `req_ready`, `rsp_valid` and `mem_req` are low.
- R10: Once raised, `mem_req` stays high with stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_inhibit | input | 1 | Bypass the cache for this access |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response doubleword valid |
| rsp_rdata | output | 64 | Response doubleword |
| mem_req | output | 1 | Memory transfer request |
| mem_write | output | 1 | Memory transfer is a write |
| mem_single | output | 1 | Single-beat transfer rather than a whole line |
| mem_addr | output | 32 | Memory address |
| mem_be | output | 8 | Byte enables for single-beat writes |
| mem_wdata | output | 256 | Line write data, or single-beat data on [63:0] |
| mem_ack | input | 1 | Transfer complete (one-cycle pulse) |
| mem_rdata | input | 256 | Line or single-beat read data, valid with mem_ack |

## Verification
A store hit has to read the old line, merge the enabled bytes, write the line back, set the dirty bit and move the tree bits, all in the cycle of the tag lookup. A stale merge or a missed state update therefore shows only on a later access. The bench provokes this with back-to-back stores to one doubleword that use disjoint byte masks, followed by a read that must return the union of both masks. Scripted miss chains in a single set then require each eviction to hit exactly the way the tree bits predict. This is judged by counting fills and writebacks and by checking the writeback address of the one modified line.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DW_W       = 64;
    localparam int unsigned WAYS       = 4;
    localparam int unsigned SETS       = 128;
    localparam int unsigned LINE_BYTES = 32;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned SET_W      = $clog2(SETS);
    localparam int unsigned TAG_W      = ADDR_W - SET_W - OFF_W;
    localparam int unsigned WAY_W      = $clog2(WAYS);
    localparam int unsigned LINE_W     = LINE_BYTES * 8;
    localparam int unsigned DW_PER_LN  = LINE_W / DW_W;
    localparam int unsigned DSEL_W     = $clog2(DW_PER_LN);
    localparam int unsigned BE_W       = DW_W / 8;
    localparam int unsigned TREE_W     = WAYS - 1;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_REFILL,
        ST_PASS
    } dc_state_e;

    typedef struct packed {
        dc_state_e          state;
        logic [WAY_W-1:0]   victim;
        logic               rsp_valid;
        logic [DW_W-1:0]    rsp_data;
    } dc_ctrl_t;
endpackage

// File: rtl/dc_plru.sv
module dc_plru
    import dcache_pkg::*;
(
    input  logic [TREE_W-1:0] tree_i,
    input  logic [WAY_W-1:0]  touch_i,
    output logic [TREE_W-1:0] tree_o,
    output logic [WAY_W-1:0]  victim_o
);
    // Three-bit tree for four ways: bit0 root, bit1 left pair, bit2 right pair.
    always_comb begin
        victim_o  = tree_i[0] ? {1'b1, tree_i[2]} : {1'b0, tree_i[1]};
        tree_o    = tree_i;
        tree_o[0] = ~touch_i[1];
        if (touch_i[1]) tree_o[2] = ~touch_i[0];
        else            tree_o[1] = ~touch_i[0];
    end

    // R4: the updated tree never designates the way just touched
    always_comb begin
        if (!$isunknown({tree_o, touch_i})) begin
            a_r4_points_away: assert ((tree_o[0] ? {1'b1, tree_o[2]} : {1'b0, tree_o[1]}) != touch_i)
                else $error("tree update points at the touched way");
        end
    end
endmodule

// File: rtl/dc_tag_match.sv
module dc_tag_match
    import dcache_pkg::*;
(
    input  logic [TAG_W-1:0]            tag_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0]             valid_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o,
    output logic                        free_any_o,
    output logic [WAY_W-1:0]            free_way_o
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    always_comb begin
        hit_way_o  = '0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])    hit_way_o  = WAY_W'(w);
            if (!valid_i[w]) free_way_o = WAY_W'(w);
        end
        hit_o      = |match;
        free_any_o = ~&valid_i;
    end

    // R1: a tag is resident in at most one way of a set
    always_comb begin
        if (!$isunknown(match)) begin
            a_r1_single_way: assert ($onehot0(match))
                else $error("tag present in several ways");
        end
    end
endmodule

// File: rtl/dcache_core.sv
module dcache_core
    import dcache_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_inhibit,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DW_W-1:0]     req_wdata,
    input  logic [BE_W-1:0]     req_be,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [DW_W-1:0]     rsp_rdata,
    output logic                mem_req,
    output logic                mem_write,
    output logic                mem_single,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BE_W-1:0]     mem_be,
    output logic [LINE_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [LINE_W-1:0]   mem_rdata
);
    logic [TAG_W-1:0]  tag_mem  [WAYS][SETS];
    logic [LINE_W-1:0] line_mem [WAYS][SETS];
    logic [WAYS-1:0]   vld_q    [SETS];
    logic [WAYS-1:0]   dirty_q  [SETS];
    logic [TREE_W-1:0] tree_q   [SETS];

    dc_ctrl_t ctrl_d, ctrl_q;

    logic [TAG_W-1:0]  a_tag;
    logic [SET_W-1:0]  a_set;
    logic [DSEL_W-1:0] a_dw;
    assign a_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign a_set = req_addr[OFF_W +: SET_W];
    assign a_dw  = req_addr[OFF_W-1 -: DSEL_W];

    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    for (genvar w = 0; w < WAYS; w++) begin : g_tags
        assign set_tags[w] = tag_mem[w][a_set];
    end

    logic             hit, free_any;
    logic [WAY_W-1:0] hit_way, free_way, lru_way, way_pick, touch_way;
    logic [TREE_W-1:0] tree_next;
    logic [WAYS-1:0]  vld_set;
    assign vld_set = vld_q[a_set];

    dc_tag_match i_match (
        .tag_i      (a_tag),
        .tags_i     (set_tags),
        .valid_i    (vld_set),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .free_any_o (free_any),
        .free_way_o (free_way)
    );

    assign touch_way = (ctrl_q.state == ST_REFILL) ? ctrl_q.victim : hit_way;

    dc_plru i_plru (
        .tree_i   (tree_q[a_set]),
        .touch_i  (touch_way),
        .tree_o   (tree_next),
        .victim_o (lru_way)
    );

    assign way_pick = free_any ? free_way : lru_way;

    // Byte-lane merge for the single-cycle read-modify-write
    logic [LINE_W-1:0] cur_line, new_line;
    logic [DW_W-1:0]   old_dw, merged_dw;
    assign cur_line = line_mem[hit_way][a_set];
    assign old_dw   = cur_line[int'(a_dw)*DW_W +: DW_W];

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign merged_dw[8*b +: 8] = req_be[b] ? req_wdata[8*b +: 8] : old_dw[8*b +: 8];
    end

    always_comb begin
        new_line = cur_line;
        new_line[int'(a_dw)*DW_W +: DW_W] = merged_dw;
    end

    logic store_we, fill_we, tree_we, ready;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.rsp_valid = 1'b0;
        ready      = 1'b0;
        store_we   = 1'b0;
        fill_we    = 1'b0;
        tree_we    = 1'b0;
        mem_req    = 1'b0;
        mem_write  = 1'b0;
        mem_single = 1'b0;
        mem_addr   = {a_tag, a_set, {OFF_W{1'b0}}};
        mem_be     = '0;
        mem_wdata  = '0;
        unique case (ctrl_q.state)
            ST_LOOKUP: begin
                if (req_valid) begin
                    if (req_inhibit) begin
                        ctrl_d.state = ST_PASS;
                    end else if (hit) begin
                        ready            = 1'b1;
                        tree_we          = 1'b1;
                        store_we         = req_write;
                        ctrl_d.rsp_valid = 1'b1;
                        ctrl_d.rsp_data  = req_write ? merged_dw : old_dw;
                    end else begin
                        ctrl_d.victim = way_pick;
                        ctrl_d.state  = (vld_set[way_pick] && dirty_q[a_set][way_pick])
                                        ? ST_EVICT : ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {tag_mem[ctrl_q.victim][a_set], a_set, {OFF_W{1'b0}}};
                mem_wdata = line_mem[ctrl_q.victim][a_set];
                if (mem_ack) ctrl_d.state = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_we      = 1'b1;
                    tree_we      = 1'b1;
                    ctrl_d.state = ST_LOOKUP;
                end
            end
            ST_PASS: begin
                mem_req         = 1'b1;
                mem_single      = 1'b1;
                mem_write       = req_write;
                mem_addr        = req_addr;
                mem_be          = req_be;
                mem_wdata[DW_W-1:0] = req_wdata;
                if (mem_ack) begin
                    ready            = 1'b1;
                    ctrl_d.rsp_valid = 1'b1;
                    ctrl_d.rsp_data  = mem_rdata[DW_W-1:0];
                    ctrl_d.state     = ST_LOOKUP;
                end
            end
            default: ctrl_d.state = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_LOOKUP, victim: '0, rsp_valid: 1'b0, rsp_data: '0};
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]   <= '0;
                dirty_q[s] <= '0;
                tree_q[s]  <= '0;
            end
        end else begin
            ctrl_q <= ctrl_d;
            if (tree_we) tree_q[a_set] <= tree_next;
            if (store_we) dirty_q[a_set][hit_way] <= 1'b1;
            if (fill_we) begin
                vld_q[a_set][ctrl_q.victim]   <= 1'b1;
                dirty_q[a_set][ctrl_q.victim] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (store_we) line_mem[hit_way][a_set] <= new_line;
        if (fill_we) begin
            line_mem[ctrl_q.victim][a_set] <= mem_rdata;
            tag_mem[ctrl_q.victim][a_set]  <= a_tag;
        end
    end

    assign req_ready = ready;
    assign rsp_valid = ctrl_q.rsp_valid;
    assign rsp_rdata = ctrl_q.rsp_data;

    // R2: a response follows acceptance after exactly one cycle
    a_r2_rsp_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> rsp_valid);
    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !rsp_valid);
    // R10: a transfer request is held steady until acknowledged
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
    // R6: an acknowledged line write is followed by the line fetch
    a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_write && !mem_single && mem_ack) |=> (mem_req && !mem_write && !mem_single));
    // R5: with a free way present, the chosen victim is never a valid way
    a_r5_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_LOOKUP && req_valid && !req_inhibit && !hit && free_any)
            |-> !vld_set[way_pick]);
    // R7: line transfers are line-aligned
    a_r7_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_single) |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/test_dcache_core.sv
module test_dcache_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_inhibit = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [63:0]  req_wdata = '0;
    logic [7:0]   req_be = '0;
    logic         req_ready, rsp_valid;
    logic [63:0]  rsp_rdata;
    logic         mem_req, mem_write, mem_single;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_be;
    logic [255:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dcache_core i_dcache_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_inhibit(req_inhibit),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_single(mem_single),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_tests = 0, n_fail = 0;
    int n_fill = 0, n_wb = 0, n_single = 0;
    logic [31:0] last_wb_addr = '0;

    logic [63:0] bmem  [logic [28:0]];
    logic [63:0] ref_m [logic [28:0]];

    function automatic logic [63:0] pat(logic [28:0] k);
        logic [31:0] a = {k, 3'b000};
        return {a, ~a};
    endfunction
    function automatic logic [63:0] mem_get(logic [28:0] k);
        return bmem.exists(k) ? bmem[k] : pat(k);
    endfunction
    function automatic logic [63:0] ref_get(logic [28:0] k);
        return ref_m.exists(k) ? ref_m[k] : pat(k);
    endfunction
    function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] wd, logic [7:0] be);
        logic [63:0] r = old;
        for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder: two cycles of latency, one-cycle acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && rst_n) begin
                automatic logic [31:0] a = mem_addr;
                automatic logic w = mem_write, s = mem_single;
                automatic logic [7:0] be = mem_be;
                automatic logic [255:0] wd = mem_wdata;
                repeat (2) @(negedge clk);
                mem_rdata = '0;
                if (s) begin
                    if (w) bmem[a[31:3]] = merge(mem_get(a[31:3]), wd[63:0], be);
                    mem_rdata[63:0] = mem_get(a[31:3]);
                    n_single++;
                end else if (w) begin
                    for (int k = 0; k < 4; k++) bmem[{a[31:5], 2'(k)}] = wd[64*k +: 64];
                    last_wb_addr = a;
                    n_wb++;
                end else begin
                    for (int k = 0; k < 4; k++) mem_rdata[64*k +: 64] = mem_get({a[31:5], 2'(k)});
                    n_fill++;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic do_access(input bit wr, input bit inh, input logic [31:0] a,
                             input logic [63:0] wd, input logic [7:0] be,
                             output logic [63:0] rd, output bit got);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_inhibit = inh;
        req_addr = a; req_wdata = wd; req_be = be;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        got = rsp_valid;
        rd  = rsp_rdata;
    endtask

    typedef struct packed {
        logic        wr;
        logic        inh;
        logic [31:0] addr;
        logic [63:0] wd;
        logic [7:0]  be;
        logic [1:0]  nf;
        logic [1:0]  nw;
        logic [1:0]  ns;
        logic [31:0] wba;
    } vec_t;

    // All cached vectors map to set 0; tags 0..8 exercise fill order and tree replacement.
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h0000_0008, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b1, 1'b0, 32'h0000_0008, 64'h1122_3344_5566_7788, 8'h0F, 2'd0, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_1000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_2000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_3010, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_0008, 64'h0, 8'h00, 2'd0, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_4000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_2000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_1000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_3000, 64'h0, 8'h00, 2'd1, 2'd1, 2'd0, 32'h0000_0000},
        '{1'b0, 1'b0, 32'h0000_0008, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b1, 1'b0, 32'h0000_0018, 64'hAABB_CCDD_EEFF_0011, 8'h81, 2'd0, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b1, 32'h0000_0008, 64'h0, 8'h00, 2'd0, 2'd0, 2'd1, 32'h0},
        '{1'b1, 1'b1, 32'h0000_5000, 64'h0000_0000_0000_BEEF, 8'h03, 2'd0, 2'd0, 2'd1, 32'h0},
        '{1'b0, 1'b0, 32'h0000_5000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_3018, 64'h0, 8'h00, 2'd0, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_6000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_7000, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0},
        '{1'b0, 1'b0, 32'h0000_8000, 64'h0, 8'h00, 2'd1, 2'd1, 2'd0, 32'h0000_0000},
        '{1'b0, 1'b0, 32'h0000_0018, 64'h0, 8'h00, 2'd1, 2'd0, 2'd0, 32'h0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd, exp;
        bit got;
        int f0, w0, s0;
        vec_t v;
        string tag;

        repeat (3) @(negedge clk);
        // R9: quiet outputs while reset is applied
        check(req_ready == 1'b0, "R9 ready in reset", 64'(req_ready), 64'd0);
        check(rsp_valid == 1'b0, "R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check(mem_req == 1'b0, "R9 mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            f0 = n_fill; w0 = n_wb; s0 = n_single;
            if (v.wr) ref_m[v.addr[31:3]] = merge(ref_get(v.addr[31:3]), v.wd, v.be);
            exp = ref_get(v.addr[31:3]);
            do_access(v.wr, v.inh, v.addr, v.wd, v.be, rd, got);
            tag = v.inh ? "R8 bypass data" : (v.wr ? "R3 store merge" : "R1 R2 load data");
            check(got, {tag, " valid"}, 64'(got), 64'd1);
            check(rd == exp, tag, rd, exp);
            check((n_fill - f0) == int'(v.nf), "R4 R5 R7 fill count", 64'(n_fill - f0), 64'(v.nf));
            check((n_wb - w0) == int'(v.nw), "R6 writeback count", 64'(n_wb - w0), 64'(v.nw));
            check((n_single - s0) == int'(v.ns), "R8 single-beat count", 64'(n_single - s0), 64'(v.ns));
            if (v.nw != 0)
                check(last_wb_addr == v.wba, "R6 writeback address", 64'(last_wb_addr), 64'(v.wba));
        end

        // R3: back-to-back stores with disjoint masks, then read the union
        f0 = n_fill;
        ref_m[29'h3] = merge(ref_get(29'h3), 64'h0102_0304_0506_0708, 8'h0F);
        do_access(1'b1, 1'b0, 32'h0000_0018, 64'h0102_0304_0506_0708, 8'h0F, rd, got);
        ref_m[29'h3] = merge(ref_get(29'h3), 64'hF1F2_F3F4_0000_0000, 8'hF0);
        do_access(1'b1, 1'b0, 32'h0000_0018, 64'hF1F2_F3F4_0000_0000, 8'hF0, rd, got);
        exp = ref_get(29'h3);
        check(rd == exp, "R3 second store response", rd, exp);
        do_access(1'b0, 1'b0, 32'h0000_0018, 64'h0, 8'h00, rd, got);
        check(rd == 64'hF1F2_F3F4_0506_0708, "R3 merged readback", rd, 64'hF1F2_F3F4_0506_0708);
        check(n_fill == f0, "R3 hits need no fill", 64'(n_fill - f0), 64'd0);

        // R8: an inhibited access leaves nothing allocated
        do_access(1'b0, 1'b1, 32'h0000_9040, 64'h0, 8'h00, rd, got);
        f0 = n_fill;
        do_access(1'b0, 1'b0, 32'h0000_9040, 64'h0, 8'h00, rd, got);
        check((n_fill - f0) == 1, "R8 no allocation on bypass", 64'(n_fill - f0), 64'd1);
        exp = ref_get(29'h0000_9040 >> 3);
        check(rd == exp, "R8 later cached read data", rd, exp);

        // R9: reset drops resident lines, dirty data included
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        f0 = n_fill; w0 = n_wb;
        do_access(1'b0, 1'b0, 32'h0000_0018, 64'h0, 8'h00, rd, got);
        check((n_fill - f0) == 1, "R9 miss after reset", 64'(n_fill - f0), 64'd1);
        check(n_wb == w0, "R9 no writeback after reset", 64'(n_wb - w0), 64'd0);
        exp = mem_get(29'h3);
        check(rd == exp, "R9 data from memory", rd, exp);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule